// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one shift register of the most recent branch outcomes, called the global history. It also keeps one table of 2-bit saturating counters. For each lookup, the branch address and the history are combined into a table index, and the upper bit of the counter at that index gives the guess. A parameter selects one of three ways to form the index:
- from the history alone;
- from low address bits placed above the history bits;
- from low address bits XORed with the history.

The fetch side presents an address and receives the predicted direction in the same cycle. It also receives the index that was used, and carries that index along with the branch. When the branch resolves, the execute side returns the index and the real outcome. The block then trains the counter at that index and shifts the outcome into the history. Both changes are visible from the following cycle.

Top module: `gbp_predictor`

## Requirements
- R1: After a synchronous active-high reset, the history is all zeros and every counter holds 01 (weakly not taken), so every lookup predicts not taken.
- R2: The history is a HIST_W-bit shift register. Each accepted resolve shifts its outcome in at bit 0 (1 = taken). With MODE = IDX_GLOBAL the index equals the history and ignores the address, so resolving taken, taken, not taken, not taken from reset gives index 4'b1100.
- R3: With MODE = IDX_CONCAT the index is SEL_W + HIST_W bits wide: {lk_addr[SEL_W-1:0], history}, with the address bits in the upper part.
- R4: With MODE = IDX_XOR the index is lk_addr[HIST_W-1:0] XOR history.
- R5: A counter moves up by one on a taken resolve and down by one on a not-taken resolve. It saturates at 11 and at 00.
- R6: lk_taken is bit 1 of the counter at lk_index. Both outputs depend combinationally on lk_addr in the same cycle.
- R7: A resolve updates the counter at rs_index, whatever the current lookup is. The new counter value and the new history are seen by lookups from the next cycle on.
- R8: While rs_valid is low, rs_taken and rs_index have no effect: the history and all counters keep their values.
- R9: If a lookup and a resolve hit the same index in the same cycle, the lookup returns the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | ADDR_W | Branch address being looked up |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_index | output | IDX_W | Table index used for this lookup |
| rs_valid | input | 1 | A branch outcome is being reported |
| rs_taken | input | 1 | Actual outcome of the resolved branch |
| rs_index | input | IDX_W | Index that was returned when this branch was predicted |

## Verification
Three instances, one per index mode, receive the same stimulus. A behavioural model is compared against all three on every cycle.

The directed part first builds a known history (taken, taken, not taken, not taken). It then reads the index in each mode, which tells whether the address was ignored, placed above the history, or XORed with it.

Runs of five identical outcomes at one counter followed by a reversal show whether the counter saturates or wraps. A lookup and a resolve aimed at the same index in one cycle show whether a write can reach the read early. Idle cycles with rs_taken held high show that the outcome is ignored without rs_valid. A long random phase then mixes all of these cases.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

  typedef enum logic [1:0] {
    IDX_GLOBAL = 2'd0,
    IDX_CONCAT = 2'd1,
    IDX_XOR    = 2'd2
  } idx_mode_e;

  localparam logic [1:0] CTR_RESET = 2'b01;

  function automatic int idx_width(idx_mode_e mode, int hist_w, int sel_w);
    return (mode == IDX_CONCAT) ? (sel_w + hist_w) : hist_w;
  endfunction

  function automatic logic [1:0] ctr_step(logic [1:0] c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction

endpackage

// File: rtl/gbp_history.sv
module gbp_history #(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)      hist_q <= '0;
    else if (upd) hist_q <= {hist_q[HIST_W-2:0], outcome};
  end

  assign hist = hist_q;
endmodule

// File: rtl/gbp_index_hash.sv
module gbp_index_hash #(
  parameter gbp_pkg::idx_mode_e MODE = gbp_pkg::IDX_XOR,
  parameter int ADDR_W = 16,
  parameter int HIST_W = 4,
  parameter int SEL_W  = 4,
  localparam int IDX_W = gbp_pkg::idx_width(MODE, HIST_W, SEL_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  logic addr_unused;
  assign addr_unused = ^addr;

  generate
    if (MODE == gbp_pkg::IDX_GLOBAL) begin : g_global
      assign idx = hist;
    end else if (MODE == gbp_pkg::IDX_CONCAT) begin : g_concat
      assign idx = {addr[SEL_W-1:0], hist};
    end else begin : g_xor
      assign idx = addr[HIST_W-1:0] ^ hist;
    end
  endgenerate
endmodule

// File: rtl/gbp_counter_table.sv
module gbp_counter_table #(
  parameter int IDX_W = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic             wr_taken,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [1:0]       wr_old
);
  logic [1:0] ctr_q [DEPTH];

  assign rd_ctr = ctr_q[rd_idx];
  assign wr_old = ctr_q[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= gbp_pkg::CTR_RESET;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= gbp_pkg::ctr_step(wr_old, wr_taken);
    end
  end
endmodule

// File: rtl/gbp_predictor.sv
module gbp_predictor #(
  parameter gbp_pkg::idx_mode_e MODE = gbp_pkg::IDX_XOR,
  parameter int ADDR_W = 16,
  parameter int HIST_W = 4,
  parameter int SEL_W  = 4,
  localparam int IDX_W = gbp_pkg::idx_width(MODE, HIST_W, SEL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_taken,
  output logic [IDX_W-1:0]  lk_index,
  input  logic              rs_valid,
  input  logic              rs_taken,
  input  logic [IDX_W-1:0]  rs_index
);
  logic [HIST_W-1:0] hist;
  logic [1:0]        lk_ctr;
  logic [1:0]        rs_ctr;

  gbp_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .upd(rs_valid), .outcome(rs_taken), .hist(hist)
  );

  gbp_index_hash #(.MODE(MODE), .ADDR_W(ADDR_W), .HIST_W(HIST_W), .SEL_W(SEL_W)) u_hash (
    .addr(lk_addr), .hist(hist), .idx(lk_index)
  );

  gbp_counter_table #(.IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst(rst),
    .rd_idx(lk_index), .rd_ctr(lk_ctr),
    .wr_en(rs_valid), .wr_taken(rs_taken), .wr_idx(rs_index), .wr_old(rs_ctr)
  );

  assign lk_taken = lk_ctr[1];
endmodule

// File: rtl/gbp_checker.sv
module gbp_checker #(
  parameter int HIST_W = 4,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rs_valid,
  input logic              rs_taken,
  input logic [IDX_W-1:0]  rs_index,
  input logic [HIST_W-1:0] hist,
  input logic [1:0]        rs_ctr
);
  // R1
  reset_hist_chk: assert property (@(posedge clk) rst |=> (hist == '0));
  // R1
  reset_ctr_chk: assert property (@(posedge clk) rst |=> (rs_ctr == 2'b01));
  // R2
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    rs_valid |=> (hist == {$past(hist[HIST_W-2:0]), $past(rs_taken)}));
  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |=> $stable(hist));
  // R5
  ctr_up_chk: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && $past(rs_valid) && $past(rs_taken) && rs_index == $past(rs_index))
    |-> (rs_ctr == (($past(rs_ctr) == 2'b11) ? 2'b11 : $past(rs_ctr) + 2'b01)));
  // R5
  ctr_down_chk: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && $past(rs_valid) && !$past(rs_taken) && rs_index == $past(rs_index))
    |-> (rs_ctr == (($past(rs_ctr) == 2'b00) ? 2'b00 : $past(rs_ctr) - 2'b01)));
endmodule

bind gbp_predictor gbp_checker #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .rs_valid(rs_valid), .rs_taken(rs_taken),
  .rs_index(rs_index), .hist(hist), .rs_ctr(rs_ctr)
);

// File: tb/gbp_predictor_test.sv
module gbp_predictor_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] lk_addr = '0;
  logic rs_valid = 1'b0, rs_taken = 1'b0;
  logic [3:0] ri_x = '0, ri_g = '0;
  logic [7:0] ri_s = '0;
  logic p_x, p_g, p_s;
  logic [3:0] i_x, i_g;
  logic [7:0] i_s;

  int nchk = 0, nerr = 0;
  int hist = 0;
  int ctr_x [16];
  int ctr_g [16];
  int ctr_s [256];

  always #5 clk = ~clk;

  gbp_predictor #(.MODE(gbp_pkg::IDX_XOR), .ADDR_W(16), .HIST_W(4), .SEL_W(4)) uut (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_taken(p_x), .lk_index(i_x),
    .rs_valid(rs_valid), .rs_taken(rs_taken), .rs_index(ri_x));
  gbp_predictor #(.MODE(gbp_pkg::IDX_GLOBAL), .ADDR_W(16), .HIST_W(4), .SEL_W(4)) uut_gag (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_taken(p_g), .lk_index(i_g),
    .rs_valid(rs_valid), .rs_taken(rs_taken), .rs_index(ri_g));
  gbp_predictor #(.MODE(gbp_pkg::IDX_CONCAT), .ADDR_W(16), .HIST_W(4), .SEL_W(4)) uut_sel (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_taken(p_s), .lk_index(i_s),
    .rs_valid(rs_valid), .rs_taken(rs_taken), .rs_index(ri_s));

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mx(int a); return (a & 15) ^ hist; endfunction
  function automatic int ms(int a); return ((a & 15) << 4) | hist; endfunction
  function automatic int step(int c, bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  // compare all outputs against the model, away from the clock edge
  task automatic probe();
    #1;
    chk("R4 xor index", i_x, mx(lk_addr));
    chk("R2 global index", i_g, hist);
    chk("R3 concat index", i_s, ms(lk_addr));
    chk("R6 xor prediction", p_x, ctr_x[mx(lk_addr)] >> 1);
    chk("R6 global prediction", p_g, ctr_g[hist] >> 1);
    chk("R6 concat prediction", p_s, ctr_s[ms(lk_addr)] >> 1);
  endtask

  // R7: model state changes at the edge and is seen from the next cycle
  task automatic advance();
    @(posedge clk);
    if (rs_valid) begin
      ctr_x[ri_x] = step(ctr_x[ri_x], rs_taken);
      ctr_g[ri_g] = step(ctr_g[ri_g], rs_taken);
      ctr_s[ri_s] = step(ctr_s[ri_s], rs_taken);
      hist = ((hist << 1) | int'(rs_taken)) & 15;
    end
    @(negedge clk);
  endtask

  task automatic look(int a);
    lk_addr = 16'(a); rs_valid = 0;
    probe();
  endtask

  task automatic res_at(bit t, int ix);
    rs_valid = 1; rs_taken = t; ri_x = 4'(ix); ri_g = 4'(ix); ri_s = 8'(ix);
    probe(); advance();
  endtask

  task automatic res_cur(bit t);
    rs_valid = 1; rs_taken = t;
    ri_x = 4'(mx(lk_addr)); ri_g = 4'(hist); ri_s = 8'(ms(lk_addr));
    probe(); advance();
  endtask

  initial begin
    #100000;
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int snap_i, snap_p;
    foreach (ctr_x[i]) ctr_x[i] = 1;
    foreach (ctr_g[i]) ctr_g[i] = 1;
    foreach (ctr_s[i]) ctr_s[i] = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1: everything weakly not taken, history zero
    for (int a = 0; a < 16; a++) begin
      look(a * 17);
      chk("R1 reset prediction", p_x | p_g | p_s, 0);
      advance();
    end
    look(0); chk("R1 reset history", i_g, 0); advance();

    // R2: history 1100
    lk_addr = 0;
    res_cur(1); res_cur(1); res_cur(0); res_cur(0);
    look(0); chk("R2 history 1100", i_g, 12); advance();
    look(5); chk("R4 5 xor 1100", i_x, 9); advance();
    look(16'h00A3); chk("R3 concat A3", i_s, 8'h3C); advance();

    // R5: saturation at the top
    for (int k = 0; k < 5; k++) res_at(1, 6);
    look(6 ^ hist); chk("R5 saturated taken", p_x, 1); advance();
    res_at(0, 6);
    look(6 ^ hist); chk("R5 one step down from 11", p_x, 1); advance();
    res_at(0, 6);
    look(6 ^ hist); chk("R5 two steps down from 11", p_x, 0); advance();
    // R5: saturation at the bottom
    for (int k = 0; k < 4; k++) res_at(0, 9);
    res_at(1, 9);
    look(9 ^ hist); chk("R5 one step up from 00", p_x, 0); advance();
    res_at(1, 9);
    look(9 ^ hist); chk("R5 two steps up from 00", p_x, 1); advance();

    // R9: same-cycle lookup and resolve at index 12 (counter 01)
    lk_addr = 16'(12 ^ hist); rs_valid = 1; rs_taken = 1;
    ri_x = 4'd12; ri_g = 4'(hist); ri_s = 8'(ms(lk_addr));
    probe(); chk("R9 lookup sees old value", p_x, 0); advance();
    look(12 ^ hist); chk("R7 update visible next cycle", p_x, 1); advance();

    // R8: outcome ignored without rs_valid
    look(3); snap_i = i_g; snap_p = p_x; advance();
    for (int k = 0; k < 4; k++) begin
      lk_addr = 3; rs_valid = 0; rs_taken = 1;
      ri_x = 4'(k); ri_g = 4'(k); ri_s = 8'(k * 40);
      probe();
      chk("R8 history unchanged", i_g, snap_i);
      chk("R8 counter unchanged", p_x, snap_p);
      advance();
    end

    // random mix, checked against the model every cycle
    for (int n = 0; n < 400; n++) begin
      lk_addr = 16'($urandom);
      rs_valid = 1'($urandom); rs_taken = 1'($urandom);
      ri_x = 4'($urandom); ri_g = 4'($urandom); ri_s = 8'($urandom);
      if (($urandom & 3) == 0) begin
        ri_x = 4'(mx(lk_addr)); ri_g = 4'(hist); ri_s = 8'(ms(lk_addr));
      end
      probe(); advance();
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule